// File: doc/BRIEF.md
# Bus Controller Frame Scheduler

This block runs the bus controller side of a MIL-STD-1553 link as a sequence of timed minor frames grouped into major frames. Two small tables hold the schedule. The minor frame table gives each minor frame a start pointer and a slot count in the message table. The message table gives each slot a message index, a primary bus and a retry policy. The host fills both tables, then sets the frame period, the number of minor frames in a major frame, a repeat count and a continuous-mode bit, and pulses `go`.

For each listed message the scheduler requests a transfer from a downstream transmitter. It uses a start/busy/done handshake and keeps one message in flight at a time. A failed message is retried once, on the same bus or on the other one, as the slot selects. A free-running period timer marks the frame boundaries. Message lengths, response delays and retries therefore never move a boundary. At a boundary, any messages still pending are dropped and an overrun is flagged. Completion pulses mark every minor frame, every major frame and the end of the schedule. After the programmed number of major frames the block returns to idle by itself. A `halt` request takes effect at the next minor frame boundary.

Top module: `bc_frame_sched`

## Requirements
- R1: After reset `active`, `tx_start`, `minor_done`, `major_done`, `sched_done` and `overrun` are all low.
- R2: A host write with `hw_tbl`=0 stores minor frame entry `hw_addr`, with the message table start pointer in `hw_data[11:0]` and the slot count in `hw_data[23:12]`. A write with `hw_tbl`=1 stores message slot `hw_addr`, with the message index in `hw_data[IDX_W-1:0]`, the primary bus in bit 22 and the alternate-bus retry flag in bit 23. `tx_index` and `tx_bus` carry these fields when the slot is issued.
- R3: A minor frame lasts exactly TICK_DIV × `cfg_period` clock cycles (a period of 0 counts as 1). The first `minor_done` pulse comes that many cycles after the edge that accepts `go`, and each later pulse follows the one before by the same count, whatever the message traffic does.
- R4: The slots of a minor frame are issued in table order. `tx_start` is a single-cycle request, raised only while `tx_busy` is low. The next slot is not requested until `tx_done` has closed the current one.
- R5: When `tx_done` comes with `tx_ok` low on a first attempt, the same slot is requested once more. The retry goes on the primary bus if the retry flag is 0 and on the other bus if it is 1. A second failure moves on to the next slot.
- R6: If a boundary arrives while slots of the current minor frame are unfinished, those slots are dropped and `overrun` pulses together with `minor_done`.
- R7: Minor frames run in the order 0 to `cfg_minors`−1 (0 counts as 1, and values above MINOR_DEPTH are clamped). `major_done` pulses together with the `minor_done` of the last one.
- R8: With `cfg_forever` low the schedule runs `cfg_reps`+1 major frames. It then pulses `sched_done` and drops `active` at that boundary. With `cfg_forever` high it runs until halted.
- R9: A `halt` pulse while active stops the schedule at the next boundary, with `sched_done` and no further frames.
- R10: A `go` pulse while active is ignored and does not move the frame timing.
- R11: A minor frame with a slot count of 0 issues no request and raises no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_en | input | 1 | Table write strobe |
| hw_tbl | input | 1 | Table select: 0 minor frame table, 1 message table |
| hw_addr | input | 11 | Table entry address |
| hw_data | input | 24 | Table entry contents |
| cfg_period | input | PER_W | Minor frame period in timer units |
| cfg_minors | input | 11 | Minor frames per major frame |
| cfg_reps | input | REP_W | Major frame repeats minus one |
| cfg_forever | input | 1 | Repeat major frames until halted |
| go | input | 1 | Start pulse |
| halt | input | 1 | Stop-at-boundary pulse |
| tx_start | output | 1 | Transfer request to the transmitter |
| tx_index | output | IDX_W | Message index of the request |
| tx_bus | output | 1 | Bus selected for the request |
| tx_busy | input | 1 | Transmitter occupied |
| tx_done | input | 1 | Transfer finished pulse |
| tx_ok | input | 1 | Transfer succeeded, valid with tx_done |
| active | output | 1 | Schedule running |
| minor_done | output | 1 | Minor frame boundary pulse |
| major_done | output | 1 | Major frame boundary pulse |
| sched_done | output | 1 | Schedule ended pulse |
| overrun | output | 1 | Slots dropped at this boundary |

## Verification
The bench builds the block with TICK_DIV=4, MINOR_DEPTH=8 and MSG_DEPTH=16. A minor frame then spans only a few dozen cycles, so several whole major frames, repeat-count expiry, continuous running and a halt all fit in a short run. The small tables let one schedule mix a two-slot frame, an empty frame, and a frame where both retry policies fail. A slow transmitter latency paired with a short period pushes every frame into overrun.

// File: rtl/bc_frame_sched.sv
module bc_frame_sched #(
  parameter int TICK_DIV    = 5000,
  parameter int PER_W       = 16,
  parameter int IDX_W       = 8,
  parameter int MINOR_DEPTH = 32,
  parameter int MSG_DEPTH   = 64,
  parameter int REP_W       = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_en,
  input  logic             hw_tbl,
  input  logic [10:0]      hw_addr,
  input  logic [23:0]      hw_data,
  input  logic [PER_W-1:0] cfg_period,
  input  logic [10:0]      cfg_minors,
  input  logic [REP_W-1:0] cfg_reps,
  input  logic             cfg_forever,
  input  logic             go,
  input  logic             halt,
  output logic             tx_start,
  output logic [IDX_W-1:0] tx_index,
  output logic             tx_bus,
  input  logic             tx_busy,
  input  logic             tx_done,
  input  logic             tx_ok,
  output logic             active,
  output logic             minor_done,
  output logic             major_done,
  output logic             sched_done,
  output logic             overrun
);
  localparam int MN_AW = (MINOR_DEPTH > 1) ? $clog2(MINOR_DEPTH) : 1;
  localparam int MS_AW = (MSG_DEPTH > 1) ? $clog2(MSG_DEPTH) : 1;
  localparam int CNT_W = $clog2(MSG_DEPTH + 1);
  localparam int PD_W  = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int ME_W  = IDX_W + 2;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_BUSY, S_WAIT} st_t;

  logic [MS_AW+CNT_W-1:0] minor_tab [MINOR_DEPTH];
  logic [ME_W-1:0]        msg_tab   [MSG_DEPTH];

  st_t              st;
  logic [PD_W-1:0]  pre;
  logic [PER_W-1:0] units, per_q;
  logic [MN_AW:0]   mn_q, mn_new;
  logic [MN_AW-1:0] minor_i, nxt_minor, load_idx;
  logic [REP_W-1:0] reps_left;
  logic             forever_q, stop_pend, retried;
  logic [MS_AW-1:0] msg_ptr;
  logic [CNT_W-1:0] msg_left;
  logic [MS_AW+CNT_W-1:0] ent;
  logic [ME_W-1:0]  me;
  logic             frame_tick, last_minor, ending;
  logic             unused_hw;

  assign unused_hw = ^{hw_data, hw_addr};

  always_ff @(posedge clk) begin
    if (hw_en && !hw_tbl && int'(hw_addr) < MINOR_DEPTH)
      minor_tab[hw_addr[MN_AW-1:0]] <= {hw_data[12 +: CNT_W], hw_data[MS_AW-1:0]};
    if (hw_en && hw_tbl && int'(hw_addr) < MSG_DEPTH)
      msg_tab[hw_addr[MS_AW-1:0]] <= {hw_data[23], hw_data[22], hw_data[IDX_W-1:0]};
  end

  assign mn_new = (cfg_minors == 11'd0) ? (MN_AW+1)'(1) :
                  (int'(cfg_minors) > MINOR_DEPTH) ? (MN_AW+1)'(MINOR_DEPTH) :
                  cfg_minors[MN_AW:0];

  assign active     = (st != S_IDLE);
  assign frame_tick = active && (pre == PD_W'(TICK_DIV - 1)) && (units == per_q - 1'b1);
  assign last_minor = ({1'b0, minor_i} == mn_q - 1'b1);
  assign nxt_minor  = last_minor ? '0 : minor_i + 1'b1;
  assign load_idx   = active ? nxt_minor : '0;
  assign ent        = minor_tab[load_idx];
  assign me         = msg_tab[msg_ptr];
  assign ending     = stop_pend || halt || (last_minor && !forever_q && reps_left == '0);

  assign tx_index = me[IDX_W-1:0];
  assign tx_bus   = retried ? (me[IDX_W] ^ me[IDX_W+1]) : me[IDX_W];
  assign tx_start = (st == S_ISSUE) && (msg_left != '0) && !tx_busy && !frame_tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      pre <= '0;
      units <= '0;
      per_q <= PER_W'(1);
      mn_q <= (MN_AW+1)'(1);
      minor_i <= '0;
      reps_left <= '0;
      forever_q <= 1'b0;
      stop_pend <= 1'b0;
      retried <= 1'b0;
      msg_ptr <= '0;
      msg_left <= '0;
      minor_done <= 1'b0;
      major_done <= 1'b0;
      sched_done <= 1'b0;
      overrun <= 1'b0;
    end else begin
      minor_done <= 1'b0;
      major_done <= 1'b0;
      sched_done <= 1'b0;
      overrun <= 1'b0;
      if (st == S_IDLE) begin
        if (go) begin
          per_q <= (cfg_period == '0) ? PER_W'(1) : cfg_period;
          mn_q <= mn_new;
          reps_left <= cfg_reps;
          forever_q <= cfg_forever;
          stop_pend <= 1'b0;
          pre <= '0;
          units <= '0;
          minor_i <= '0;
          msg_ptr <= ent[MS_AW-1:0];
          msg_left <= ent[MS_AW +: CNT_W];
          retried <= 1'b0;
          st <= S_ISSUE;
        end
      end else begin
        if (pre == PD_W'(TICK_DIV - 1)) begin
          pre <= '0;
          units <= (units == per_q - 1'b1) ? '0 : units + 1'b1;
        end else begin
          pre <= pre + 1'b1;
        end
        if (halt) stop_pend <= 1'b1;
        if (frame_tick) begin
          minor_done <= 1'b1;
          overrun <= (st == S_BUSY) || (st == S_ISSUE && msg_left != '0);
          major_done <= last_minor;
          retried <= 1'b0;
          if (ending) begin
            sched_done <= 1'b1;
            st <= S_IDLE;
          end else begin
            minor_i <= nxt_minor;
            if (last_minor && !forever_q) reps_left <= reps_left - 1'b1;
            msg_ptr <= ent[MS_AW-1:0];
            msg_left <= ent[MS_AW +: CNT_W];
            st <= S_ISSUE;
          end
        end else begin
          case (st)
            S_ISSUE: begin
              if (msg_left == '0) st <= S_WAIT;
              else if (!tx_busy) st <= S_BUSY;
            end
            S_BUSY: begin
              if (tx_done) begin
                if (!tx_ok && !retried) begin
                  retried <= 1'b1;
                end else begin
                  retried <= 1'b0;
                  msg_ptr <= msg_ptr + 1'b1;
                  msg_left <= msg_left - 1'b1;
                end
                st <= S_ISSUE;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/bc_frame_sched_chk.sv
module bc_frame_sched_chk #(
  parameter int TICK_DIV = 5000,
  parameter int PER_W    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_start,
  input logic             active,
  input logic             minor_done,
  input logic             major_done,
  input logic             sched_done,
  input logic             overrun,
  input logic [PER_W-1:0] per_q
);
  logic [31:0] win;

  always_ff @(posedge clk) begin
    if (!rst_n || !active) win <= '0;
    else if (minor_done) win <= 32'd1;
    else win <= win + 32'd1;
  end

  a_r3_frame_length: assert property (@(posedge clk) disable iff (!rst_n)
    minor_done |-> (win == 32'(TICK_DIV) * 32'(per_q)));

  a_r4_single_cycle_start: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);

  a_r4_start_while_running: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> active);

  a_r6_overrun_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> minor_done);

  a_r7_major_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    major_done |-> minor_done);

  a_r8_end_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
    sched_done |-> (minor_done && !active));
endmodule

bind bc_frame_sched bc_frame_sched_chk #(.TICK_DIV(TICK_DIV), .PER_W(PER_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .active(active),
  .minor_done(minor_done), .major_done(major_done), .sched_done(sched_done),
  .overrun(overrun), .per_q(per_q)
);

// File: tb/test_bc_frame_sched.sv
module test_bc_frame_sched;
  logic clk = 1'b0, rst_n = 1'b0;
  logic hw_en = 1'b0, hw_tbl = 1'b0;
  logic [10:0] hw_addr = '0;
  logic [23:0] hw_data = '0;
  logic [15:0] cfg_period = '0;
  logic [10:0] cfg_minors = '0;
  logic [14:0] cfg_reps = '0;
  logic cfg_forever = 1'b0, go = 1'b0, halt = 1'b0;
  logic tx_start, tx_bus;
  logic [7:0] tx_index;
  logic tx_busy = 1'b0, tx_done = 1'b0, tx_ok = 1'b0;
  logic active, minor_done, major_done, sched_done, overrun;

  bc_frame_sched #(.TICK_DIV(4), .PER_W(16), .IDX_W(8), .MINOR_DEPTH(8),
                   .MSG_DEPTH(16), .REP_W(15)) i_bc_frame_sched (
    .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .hw_tbl(hw_tbl), .hw_addr(hw_addr),
    .hw_data(hw_data), .cfg_period(cfg_period), .cfg_minors(cfg_minors),
    .cfg_reps(cfg_reps), .cfg_forever(cfg_forever), .go(go), .halt(halt),
    .tx_start(tx_start), .tx_index(tx_index), .tx_bus(tx_bus), .tx_busy(tx_busy),
    .tx_done(tx_done), .tx_ok(tx_ok), .active(active), .minor_done(minor_done),
    .major_done(major_done), .sched_done(sched_done), .overrun(overrun)
  );

  always #10 clk = ~clk;

  int cyc = 0, checks = 0, failures = 0;
  int fcnt = 0, exp_nb = 0, flen = 40, mn = 1, tx_count = 0, lat = 3, bcnt = 0;
  bit exp_ovr = 0, sb_on = 0, fail_mode = 0, acc = 0, f_now = 0, seen32 = 0;
  logic [8:0] exp_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_minor(input int a, input int base, input int cnt);
    @(negedge clk);
    hw_en = 1; hw_tbl = 0; hw_addr = 11'(a);
    hw_data = {12'(cnt), 12'(base)};
    @(negedge clk);
    hw_en = 0;
  endtask

  task automatic wr_msg(input int a, input logic [7:0] idx, input bit bus, input bit alt);
    @(negedge clk);
    hw_en = 1; hw_tbl = 1; hw_addr = 11'(a);
    hw_data = {alt, bus, 14'd0, idx};
    @(negedge clk);
    hw_en = 0;
  endtask

  task automatic pulse_go(input bit first);
    @(negedge clk);
    go = 1;
    if (first) begin
      fcnt = 0;
      exp_nb = cyc + 1 + flen;
    end
    @(negedge clk);
    go = 0;
  endtask

  // transmitter model and scoreboard consumer
  always begin
    @(negedge clk);
    tx_done = 0;
    if (acc) begin
      acc = 0; tx_busy = 1; bcnt = lat;
    end else if (bcnt > 0) begin
      bcnt--;
      if (bcnt == 0) begin
        tx_busy = 0; tx_done = 1; tx_ok = !f_now;
      end
    end
    #1;
    if (tx_start && !acc) begin
      check(!tx_busy, "R4 start while busy", tx_busy, 0);
      acc = 1;
      tx_count++;
      if (tx_index == 8'h32) seen32 = 1;
      f_now = fail_mode && ((tx_index == 8'h21 && !tx_bus) || tx_index == 8'h22);
      if (sb_on) begin
        if (exp_q.size() == 0) check(0, "R4 unexpected request", {tx_bus, tx_index}, 0);
        else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          check({tx_bus, tx_index} == e, "R2/R4/R5 request order and fields",
                {tx_bus, tx_index}, e);
        end
      end
    end
  end

  // frame flag monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (minor_done) begin
        fcnt++;
        check(cyc == exp_nb, "R3 boundary cycle", cyc, exp_nb);
        exp_nb += flen;
        check(major_done == ((fcnt % mn) == 0), "R7 major flag", major_done, (fcnt % mn) == 0);
        check(overrun == exp_ovr, "R6 overrun flag", overrun, exp_ovr);
      end else if (major_done || overrun || sched_done) begin
        check(0, "R7 flag without boundary", {major_done, overrun, sched_done}, 0);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check({active, tx_start, minor_done, major_done, sched_done, overrun} == 6'b0,
          "R1 reset state", {active, tx_start, minor_done, major_done, sched_done, overrun}, 0);

    // scenario A: three minor frames, two major frames, retries
    wr_msg(0, 8'h11, 0, 0);
    wr_msg(1, 8'h12, 1, 0);
    wr_msg(2, 8'h21, 0, 1);
    wr_msg(3, 8'h22, 1, 0);
    wr_minor(0, 0, 2);
    wr_minor(1, 5, 0);
    wr_minor(2, 2, 2);
    repeat (2) begin
      exp_q.push_back(9'h011); exp_q.push_back(9'h112);
      exp_q.push_back(9'h021); exp_q.push_back(9'h121);
      exp_q.push_back(9'h122); exp_q.push_back(9'h122);
    end
    lat = 3; fail_mode = 1; sb_on = 1; mn = 3; flen = 40; exp_ovr = 0;
    cfg_period = 16'd10; cfg_minors = 11'd3; cfg_reps = 15'd1; cfg_forever = 0;
    pulse_go(1);
    check(active == 1, "R8 running after go", active, 1);
    wait (fcnt == 2);
    check(tx_count == 2, "R11 empty minor frame issues nothing", tx_count, 2);
    wait (fcnt == 6);
    check(sched_done == 1, "R8 schedule end pulse", sched_done, 1);
    check(active == 0, "R8 idle after repeats", active, 0);
    repeat (20) @(negedge clk);
    check(fcnt == 6, "R8 no frames after end", fcnt, 6);
    check(exp_q.size() == 0, "R5 all requests and retries issued", exp_q.size(), 0);

    // scenario B: slow transmitter, continuous, restart ignored, halt
    sb_on = 0; fail_mode = 0; lat = 20;
    wr_msg(8, 8'h31, 0, 0);
    wr_msg(9, 8'h32, 1, 0);
    wr_minor(0, 8, 2);
    mn = 1; flen = 12; exp_ovr = 1;
    cfg_period = 16'd3; cfg_minors = 11'd1; cfg_reps = 15'd0; cfg_forever = 1;
    pulse_go(1);
    wait (fcnt == 2);
    go = 1;
    @(negedge clk);
    go = 0;
    wait (fcnt == 5);
    check(active == 1, "R8 continuous runs past count", active, 1);
    check(fcnt == 5, "R10 go while active keeps timing", fcnt, 5);
    repeat (3) @(negedge clk);
    halt = 1;
    @(negedge clk);
    halt = 0;
    wait (fcnt == 6);
    check(cyc == exp_nb - flen, "R9 halt at next boundary", cyc, exp_nb - flen);
    check(sched_done == 1 && active == 0, "R9 halt ends schedule", {sched_done, active}, 2'b10);
    check(seen32 == 0, "R6 pending slot dropped", seen32, 0);
    repeat (40) @(negedge clk);
    check(fcnt == 6 && active == 0, "R9 stays idle after halt", fcnt, 6);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule